// File: doc/BRIEF.md
# MDIO Management Controller

This block is a bus-mapped master for the two-wire PHY management interface (MDC clock plus bidirectional MDIO data). A host on a simple 32-bit word bus programs a PHY address, a register address and, for writes, a 16-bit value. It then sets a command bit. The controller serialises a standard clause-22 management frame on MDIO and clocks it with an MDC derived from the system clock by a fixed divider. For reads it releases MDIO for the turnaround and data phases and shifts in the PHY's reply.

Two word registers are visible. The command/status word at byte offset 0 holds the two self-clearing command bits, the two 5-bit address fields and the last value read. The write-data word at byte offset 4 holds the outgoing value. Software polls the command bit it set; the command bit drops when the frame ends, and for a read the reply is already in the low half of the same word.

MDIO is presented as a split pad interface (output value, output enable, input) so that the tri-state buffer sits in the pad ring.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the command/status word reads all zero (bit 27 write command, bit 26 read command, bits 15:0 read value), MDC is low and MDIO is not driven (mdioOe low).
- R2: The command/status word is at byte address 0 and the write-data word at byte address 4. Bits 25:21 of the command/status word hold the PHY register address and bits 20:16 hold the PHY address, and both read back as written. The write-data word reads back as the full 32 bits written. A command/status write with bits 27 and 26 both clear starts no frame.
- R3: Setting bit 27 sends a write frame, sampled on MDC rising edges: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then bits 15:0 of the write-data word. Every field goes MSB first, and MDIO is driven for all 64 bits.
- R4: Setting bit 26 sends a read frame: 32 ones, start 01, opcode 10, PHY address, register address. MDIO is released for the last 18 bit times (turnaround and data). The 16 data bits are sampled on MDC rising edges MSB first and returned in bits 15:0 of the command/status word.
- R5: The command bit that was set reads 1 for the whole frame and clears in the system cycle that ends the last bit; for a read the new value is in bits 15:0 in that same cycle. A write frame leaves bits 15:0 unchanged.
- R6: A command/status write with bits 27 and 26 both set runs a read: bit 26 reads 1, bit 27 reads 0, and a read frame is sent.
- R7: While either command bit is set, writes to the command/status word are ignored: the addresses and command bits keep their values and the frame in flight is unchanged.
- R8: MDC is high for MDC_HALF system clocks and low for MDC_HALF system clocks, and is held low between frames. The default of 20 gives 2.5 MHz from a 100 MHz system clock.
- R9: MDIO is released between frames, and no further frame starts once a command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | Access is a write when high |
| busAddr | input | ADDR_W | Byte address of the word (0 or 4) |
| busWdata | input | BUS_W | Write data |
| busRdata | output | BUS_W | Read data for busAddr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable; low means released |
| mdioIn | input | 1 | MDIO value seen at the pad |

## Verification
Two things can land in the same cycle. A host write to the command/status word can arrive while a frame is being shifted, and the write must lose to the frame. A single write can also set both command bits, and the read must win. The first case is provoked by writing opposite addresses with both command bits set part-way through a frame. The bench then checks that the read-back fields are unchanged and that the captured frame still carries the original addresses. The second case is driven as a directed frame and also appears among the random ones; it is judged from the busy bits seen mid-frame, the opcode and output-enable pattern on the wire, and the value returned.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  // Frame geometry
  localparam int PRE_LEN      = 32;
  localparam int ADR_W        = 5;
  localparam int DAT_W        = 16;
  localparam int FRAME_LEN    = PRE_LEN + 2 + 2 + 2 * ADR_W + 2 + DAT_W;
  localparam int DRIVE_LEN_RD = PRE_LEN + 4 + 2 * ADR_W;
  localparam int DATA_START   = FRAME_LEN - DAT_W;

  // Frame field codes
  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] TA_WR    = 2'b10;

  // Command/status word bit positions
  localparam int CMD_WR_BIT = 27;
  localparam int CMD_RD_BIT = 26;
  localparam int REG_LSB    = 21;
  localparam int PHY_LSB    = 16;

  // Strobes from the register file to the serialiser
  typedef struct packed {
    logic             start;
    logic             isRead;
    logic [ADR_W-1:0] phyAd;
    logic [ADR_W-1:0] regAd;
    logic [DAT_W-1:0] wrData;
  } mdioCmd_t;

endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output mdioCmd_t          cmd,
  input  logic              frameDone,
  input  logic [DAT_W-1:0]  frameRdData
);

  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] WD_OFS   = ADDR_W'(4);
  localparam int                PAD_W    = BUS_W - (CMD_WR_BIT + 1);

  logic             goWr, goRd, busy;
  logic [ADR_W-1:0] phyAd, regAd;
  logic [DAT_W-1:0] rdData;
  logic [BUS_W-1:0] wdReg;
  logic             ctrlSel, wdSel, accept, reqRd, reqWr;

  assign ctrlSel = busSel && (busAddr == CTRL_OFS);
  assign wdSel   = busSel && (busAddr == WD_OFS);
  assign busy    = goWr || goRd;
  assign accept  = ctrlSel && busWr && !busy;
  assign reqRd   = busWdata[CMD_RD_BIT];
  assign reqWr   = busWdata[CMD_WR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goWr   <= 1'b0;
      goRd   <= 1'b0;
      phyAd  <= '0;
      regAd  <= '0;
      rdData <= '0;
    end else if (accept) begin
      phyAd <= busWdata[PHY_LSB +: ADR_W];
      regAd <= busWdata[REG_LSB +: ADR_W];
      goRd  <= reqRd;
      goWr  <= reqWr && !reqRd;   // read wins when both are requested
    end else if (frameDone) begin
      if (goRd) rdData <= frameRdData;
      goRd <= 1'b0;
      goWr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wdReg <= '0;
    else if (wdSel && busWr)  wdReg <= busWdata;
  end

  always_comb begin
    cmd.start  = accept && (reqRd || reqWr);
    cmd.isRead = reqRd;
    cmd.phyAd  = busWdata[PHY_LSB +: ADR_W];
    cmd.regAd  = busWdata[REG_LSB +: ADR_W];
    cmd.wrData = wdReg[DAT_W-1:0];
  end

  always_comb begin
    if (busAddr == CTRL_OFS)    busRdata = {{PAD_W{1'b0}}, goWr, goRd, regAd, phyAd, rdData};
    else if (busAddr == WD_OFS) busRdata = wdReg;
    else                        busRdata = '0;
  end

endmodule

// File: rtl/mdio_mgmt_serdes.sv
module mdio_mgmt_serdes
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdioCmd_t         cmd,
  input  logic             mdioIn,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic             frameDone,
  output logic [DAT_W-1:0] frameRdData
);

  localparam int CNT_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic                 running, mdcR, isRd;
  logic [CNT_W-1:0]     divCnt;
  logic [IDX_W-1:0]     bitIdx;
  logic [FRAME_LEN-1:0] shReg, frameWord;
  logic [DAT_W-1:0]     inReg;
  logic                 tick, lastBit, inData;

  assign tick    = (divCnt == CNT_W'(MDC_HALF - 1));
  assign lastBit = (bitIdx == IDX_W'(FRAME_LEN - 1));
  assign inData  = (bitIdx >= IDX_W'(DATA_START));

  // Bits past the address fields of a read are never driven; fill with ones.
  always_comb begin
    frameWord = {{PRE_LEN{1'b1}}, SOF_CODE,
                 cmd.isRead ? OP_RD : OP_WR,
                 cmd.phyAd, cmd.regAd,
                 cmd.isRead ? 2'b11 : TA_WR,
                 cmd.isRead ? {DAT_W{1'b1}} : cmd.wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      mdcR    <= 1'b0;
      isRd    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
      shReg   <= '0;
      inReg   <= '0;
    end else if (cmd.start) begin
      running <= 1'b1;
      mdcR    <= 1'b0;
      isRd    <= cmd.isRead;
      divCnt  <= '0;
      bitIdx  <= '0;
      shReg   <= frameWord;
    end else if (running) begin
      if (tick) begin
        divCnt <= '0;
        if (!mdcR) begin
          mdcR <= 1'b1;                                   // rising edge: PHY and we sample
          if (isRd && inData) inReg <= {inReg[DAT_W-2:0], mdioIn};
        end else begin
          mdcR  <= 1'b0;                                  // falling edge: next bit out
          shReg <= {shReg[FRAME_LEN-2:0], 1'b0};
          if (lastBit) running <= 1'b0;
          else         bitIdx  <= bitIdx + IDX_W'(1);
        end
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end

  assign mdc         = mdcR;
  assign mdioOut     = shReg[FRAME_LEN-1];
  assign mdioOe      = running && (!isRd || (bitIdx < IDX_W'(DRIVE_LEN_RD)));
  assign frameDone   = running && tick && mdcR && lastBit;
  assign frameRdData = inReg;

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 20,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  mdioCmd_t         cmd;
  logic             frameDone;
  logic [DAT_W-1:0] frameRdData;

  mdio_mgmt_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .busSel      (busSel),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .cmd         (cmd),
    .frameDone   (frameDone),
    .frameRdData (frameRdData)
  );

  mdio_mgmt_serdes #(.MDC_HALF(MDC_HALF)) u_serdes (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .mdioIn      (mdioIn),
    .mdc         (mdc),
    .mdioOut     (mdioOut),
    .mdioOe      (mdioOe),
    .frameDone   (frameDone),
    .frameRdData (frameRdData)
  );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int MDC_HALF = 20
) (
  input logic clk,
  input logic rstN,
  input logic cmdStart,
  input logic cmdIsRead,
  input logic rdReq,
  input logic frameDone,
  input logic mdc,
  input logic mdioOe
);

  logic        frameOn;
  logic [15:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          frameOn <= 1'b0;
    else if (cmdStart)  frameOn <= 1'b1;
    else if (frameDone) frameOn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    hiCnt <= '0;
    else if (!mdc) hiCnt <= '0;
    else          hiCnt <= hiCnt + 16'd1;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN) !frameOn |-> !mdioOe);                  // R9
  AST_IDLE_MDC_LOW:  assert property (@(posedge clk) disable iff (!rstN) !frameOn |-> !mdc);                     // R8
  AST_MDC_HIGH_TIME: assert property (@(posedge clk) disable iff (!rstN) $fell(mdc) |-> hiCnt == 16'(MDC_HALF)); // R8
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN) frameOn |-> !cmdStart);                 // R7
  AST_READ_WINS:     assert property (@(posedge clk) disable iff (!rstN) (cmdStart && rdReq) |-> cmdIsRead);     // R6
  AST_DONE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN) frameDone |-> frameOn);                 // R5

endmodule

bind mdio_mgmt mdio_mgmt_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdStart  (cmd.start),
  .cmdIsRead (cmd.isRead),
  .rdReq     (busWdata[mdio_mgmt_pkg::CMD_RD_BIT]),
  .frameDone (frameDone),
  .mdc       (mdc),
  .mdioOe    (mdioOe)
);

// File: tb/mdio_mgmt_bench.sv
module mdio_mgmt_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MDC_HALF   = 3;
  localparam int WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWr;
  logic [2:0]  busAddr;
  logic [31:0] busWdata, busRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int totalCnt = 0;
  int failCnt  = 0;
  logic [15:0] lastRd = 16'h0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdio_mgmt #(.MDC_HALF(MDC_HALF)) u_mdio_mgmt (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic readWord(input logic [2:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  function automatic logic [63:0] expFrame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    if (rd) return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h0};
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] expOe(input bit rd);
    if (rd) return {{46{1'b1}}, 18'h0};
    return {64{1'b1}};
  endfunction

  function automatic logic [31:0] expCtrl(input bit wrb, input bit rdb, input logic [4:0] r,
                                          input logic [4:0] p, input logic [15:0] rd);
    return {4'h0, wrb, rdb, r, p, rd};
  endfunction

  // One transaction with a bench PHY model; poke writes the command word mid-frame.
  task automatic doFrame(input bit wrb, input bit rdb, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input bit poke);
    logic [31:0] v, hi;
    logic [63:0] obs, oes;
    time t0;
    bit isRd;
    isRd = rdb;
    t0 = 0;
    if (!isRd) begin
      hi = $urandom;
      busWrite(3'd4, {hi[15:0], d});
      readWord(3'd4, v);
      chk("R2 write-data word readback", 64'(v), 64'({hi[15:0], d}));
    end
    hi = $urandom;
    busWrite(3'd0, {4'h0, wrb, rdb, r, p, hi[15:0]});
    mdioIn = 1'b1;
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      obs[63-k] = mdioOe ? mdioOut : 1'b0;
      oes[63-k] = mdioOe;
      if (k == 0) t0 = $time;
      if (k == 1) chk("R8 MDC period", 64'($time - t0), 64'(2 * MDC_HALF * CLK_PERIOD));
      if (k == 63) begin
        readWord(3'd0, v);
        chk("R5/R6 command bits during frame", 64'(v[27:26]), 64'({!isRd, isRd}));
      end
      @(negedge mdc);
      if (isRd && k >= 47 && k <= 62) mdioIn = d[62-k];
      if (poke && k == 10) begin
        busWrite(3'd0, {4'h0, 2'b11, ~r, ~p, 16'h0});
        readWord(3'd0, v);
        chk("R7 busy write ignored", 64'(v[27:16]), 64'({!isRd, isRd, r, p}));
      end
    end
    #1;
    readWord(3'd0, v);
    if (isRd) lastRd = d;
    chk(isRd ? "R4/R5 read result, command cleared" : "R5 write done, command cleared",
        64'(v), 64'(expCtrl(1'b0, 1'b0, r, p, lastRd)));
    chk(isRd ? "R4 read frame bits" : "R3 write frame bits", obs, expFrame(isRd, p, r, d));
    chk(isRd ? "R4 read output enable" : "R3 write output enable", oes, expOe(isRd));
    mdioIn = 1'b1;
    repeat (2 * MDC_HALF + 3) @(posedge clk);
    @(negedge clk);
    chk("R9 idle after frame", 64'({mdc, mdioOe}), 64'h0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    failCnt++;
    totalCnt++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WDOG, WDOG);
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = 3'd0; busWdata = '0; mdioIn = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    readWord(3'd0, v);
    chk("R1 command word after reset", 64'(v), 64'h0);
    chk("R1 MDC low and MDIO released", 64'({mdc, mdioOe}), 64'h0);
    readWord(3'd4, v);
    chk("R1 write-data word after reset", 64'(v), 64'h0);

    busWrite(3'd0, {4'h0, 2'b00, 5'h13, 5'h0A, 16'hBEEF});
    readWord(3'd0, v);
    chk("R2 address fields readback", 64'(v), 64'(expCtrl(1'b0, 1'b0, 5'h13, 5'h0A, 16'h0)));
    repeat (4 * MDC_HALF) @(posedge clk);
    @(negedge clk);
    chk("R2 no frame without command bit", 64'({mdc, mdioOe}), 64'h0);

    doFrame(1'b1, 1'b0, 5'h01, 5'h00, 16'h1234, 1'b0);
    doFrame(1'b0, 1'b1, 5'h1F, 5'h1F, 16'hFFFF, 1'b0);
    doFrame(1'b0, 1'b1, 5'h00, 5'h00, 16'h0000, 1'b0);
    doFrame(1'b1, 1'b1, 5'h0A, 5'h15, 16'hA55A, 1'b0);   // R6 both bits
    doFrame(1'b1, 1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b1);   // R7 poke during write
    doFrame(1'b0, 1'b1, 5'h05, 5'h02, 16'h8001, 1'b1);   // R7 poke during read

    for (int i = 0; i < 20; i++) begin
      logic [31:0] rnd;
      bit rdb, wrb, poke;
      rnd  = $urandom;
      rdb  = rnd[0];
      wrb  = rdb ? rnd[1] : 1'b1;
      poke = (rnd[3:2] == 2'b00);
      doFrame(wrb, rdb, rnd[8:4], rnd[13:9], rnd[29:14], poke);
    end

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule